// File: doc/BRIEF.md
# Split-Burst Read Request Bridge

This block sits between a compute core that wants to read memory with a minimal request interface and a full AXI4 read manager port. The core presents a byte start address and a length counted in whole data words. The bridge adds a programmable base offset to that address. It then issues as many AXI4 address-channel bursts as the length needs, each at most `MAX_BEATS` beats long, and each one starting where the previous one ended.

Returned beats come back to the core unchanged, with a data-valid strobe and a per-beat response status. The read-data ready toward the interconnect follows the core's own data-ready input, so back-pressure reaches memory with no buffering in between. When the core does not use that input, a parameter ties the ready signal high. The request-ready output is high only while no burst is pending. A core that watches it can issue the next request on the cycle after it sees the signal high.

Top module: `burst_read_bridge`

## Requirements
- R1: After reset, `req_ready` is 1, `m_arvalid` is 0 and the base offset is 0, so a request's byte address appears on `m_araddr` unchanged.
- R2: Address and length are sampled only on the clock edge where `req_valid` and `req_ready` are both 1. Later changes on `req_addr` or `req_len` have no effect on the bursts of that request.
- R3: `req_ready` is 0 from the cycle after acceptance until the address handshake of the final burst. It is 1 again on the cycle after that handshake.
- R4: A request of N words is issued as bursts of min(remaining, `MAX_BEATS`) beats, with `m_arlen` equal to beats minus 1.
- R5: Each burst after the first starts at the previous burst's address plus its beat count times the bus width in bytes.
- R6: `m_araddr` of the first burst equals the base offset plus `req_addr`. The base offset is loaded from `cfg_base` on a clock edge where `cfg_base_we` is 1.
- R7: Every burst carries `m_arburst` = 2'b01 (incrementing) and `m_arsize` = log2 of the bus width in bytes.
- R8: While `m_arvalid` is 1 and `m_arready` is 0, `m_arvalid`, `m_araddr` and `m_arlen` hold their values into the next cycle.
- R9: With `USE_DREADY`=1, `m_rready` equals `usr_dready`. With `USE_DREADY`=0, `m_rready` is constantly 1 and `usr_dready` has no effect.
- R10: `usr_dvalid` and `usr_rvalid` are 1 exactly when `m_rvalid` and `m_rready` are both 1. In those cycles `usr_data` equals `m_rdata` and `usr_resp` equals `m_rresp`.
- R11: A request with length 0 is accepted and ignored: no burst is issued and `req_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_we | input | 1 | Load strobe for the base offset |
| cfg_base | input | ADDR_W | New base offset value |
| req_valid | input | 1 | Read request valid |
| req_addr | input | ADDR_W | Request start address in bytes |
| req_len | input | LEN_W | Request length in data words |
| req_ready | output | 1 | Bridge can accept a request |
| usr_dready | input | 1 | Core can accept a data beat |
| usr_data | output | DATA_W | Returned data |
| usr_dvalid | output | 1 | Returned data valid |
| usr_resp | output | 2 | Response status of the beat |
| usr_rvalid | output | 1 | Response status valid |
| m_arvalid | output | 1 | AXI4 read address valid |
| m_arready | input | 1 | AXI4 read address ready |
| m_araddr | output | ADDR_W | AXI4 burst start address |
| m_arlen | output | 8 | AXI4 burst length minus one |
| m_arsize | output | 3 | AXI4 beat size code |
| m_arburst | output | 2 | AXI4 burst type |
| m_rvalid | input | 1 | AXI4 read data valid |
| m_rready | output | 1 | AXI4 read data ready |
| m_rdata | input | DATA_W | AXI4 read data |
| m_rresp | input | 2 | AXI4 read response |

## Verification
The bench builds two copies with the default widths: a 64-bit bus, a 32-bit address, a 16-bit length and a burst limit of 256. The first copy uses the core's data-ready and the second has it tied off. With the full 256-beat limit, lengths of 256, 257 and 600 words reach the exact-fit case, the one-beat remainder case and a three-burst split, each with an address step of 2048 bytes. Random address-ready stalls hold bursts pending, and random valid and ready patterns on the data path compare the two copies' ready behaviour side by side.

// File: rtl/rb_pkg.sv
package rb_pkg;
   typedef enum logic {
      SPL_IDLE  = 1'b0,
      SPL_ISSUE = 1'b1
   } spl_state_e;

   localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/rb_base_reg.sv
module rb_base_reg #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] wval,
   output logic [ADDR_W-1:0] base_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  base_q <= '0;
      else if (we) base_q <= wval;
   end
endmodule

// File: rtl/rb_splitter.sv
module rb_splitter
   import rb_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int MAX_BEATS = 256,
   parameter int BYTES     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic              req_ready,
   output logic              arvalid,
   input  logic              arready,
   output logic [ADDR_W-1:0] araddr,
   output logic [7:0]        arlen
);
   localparam int BEAT_W = $clog2(MAX_BEATS) + 1;

   spl_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  rem_q;
   logic [BEAT_W-1:0] beats;
   logic [BEAT_W-1:0] beats_m1;
   logic              accept;
   logic              ar_fire;

   always_comb begin
      if (rem_q > LEN_W'(MAX_BEATS)) beats = BEAT_W'(MAX_BEATS);
      else                           beats = rem_q[BEAT_W-1:0];
   end

   assign beats_m1  = beats - 1'b1;
   assign req_ready = (state_q == SPL_IDLE);
   assign accept    = req_valid && req_ready;
   assign arvalid   = (state_q == SPL_ISSUE);
   assign ar_fire   = arvalid && arready;
   assign araddr    = addr_q;
   assign arlen     = 8'(beats_m1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SPL_IDLE;
         addr_q  <= '0;
         rem_q   <= '0;
      end else if (accept) begin
         addr_q <= base + req_addr;
         rem_q  <= req_len;
         if (req_len != '0) state_q <= SPL_ISSUE;
      end else if (ar_fire) begin
         addr_q <= addr_q + ADDR_W'(beats) * ADDR_W'(BYTES);
         rem_q  <= rem_q - LEN_W'(beats);
         if (rem_q == LEN_W'(beats)) state_q <= SPL_IDLE;
      end
   end
endmodule

// File: rtl/rb_return.sv
module rb_return #(
   parameter int DATA_W     = 64,
   parameter bit USE_DREADY = 1'b1
) (
   input  logic              usr_dready,
   input  logic              rvalid,
   output logic              rready,
   input  logic [DATA_W-1:0] rdata,
   input  logic [1:0]        rresp,
   output logic [DATA_W-1:0] usr_data,
   output logic              usr_dvalid,
   output logic [1:0]        usr_resp,
   output logic              usr_rvalid
);
   logic beat;

   if (USE_DREADY) begin : g_follow
      assign rready = usr_dready;
   end else begin : g_tied
      logic unused_rdy;
      assign unused_rdy = usr_dready;
      assign rready     = 1'b1;
   end

   assign beat       = rvalid && rready;
   assign usr_data   = rdata;
   assign usr_resp   = rresp;
   assign usr_dvalid = beat;
   assign usr_rvalid = beat;
endmodule

// File: rtl/burst_read_bridge.sv
module burst_read_bridge
   import rb_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter int LEN_W      = 16,
   parameter int MAX_BEATS  = 256,
   parameter bit USE_DREADY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_base_we,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic              req_ready,
   input  logic              usr_dready,
   output logic [DATA_W-1:0] usr_data,
   output logic              usr_dvalid,
   output logic [1:0]        usr_resp,
   output logic              usr_rvalid,
   output logic              m_arvalid,
   input  logic              m_arready,
   output logic [ADDR_W-1:0] m_araddr,
   output logic [7:0]        m_arlen,
   output logic [2:0]        m_arsize,
   output logic [1:0]        m_arburst,
   input  logic              m_rvalid,
   output logic              m_rready,
   input  logic [DATA_W-1:0] m_rdata,
   input  logic [1:0]        m_rresp
);
   localparam int BYTES   = DATA_W / 8;
   localparam int SIZE_CD = $clog2(BYTES);

   if (MAX_BEATS < 1 || MAX_BEATS > 256) begin : g_bad_beats
      $error("MAX_BEATS must lie in 1..256");
   end
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0 || DATA_W > 1024) begin : g_bad_width
      $error("DATA_W must be a power of two from 8 to 1024");
   end
   if (LEN_W < $clog2(MAX_BEATS) + 1) begin : g_bad_len
      $error("LEN_W too narrow for MAX_BEATS");
   end

   logic [ADDR_W-1:0] base_q;

   rb_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_base_we),
      .wval  (cfg_base),
      .base_q(base_q)
   );

   rb_splitter #(
      .ADDR_W   (ADDR_W),
      .LEN_W    (LEN_W),
      .MAX_BEATS(MAX_BEATS),
      .BYTES    (BYTES)
   ) u_split (
      .clk      (clk),
      .rst_n    (rst_n),
      .base     (base_q),
      .req_valid(req_valid),
      .req_addr (req_addr),
      .req_len  (req_len),
      .req_ready(req_ready),
      .arvalid  (m_arvalid),
      .arready  (m_arready),
      .araddr   (m_araddr),
      .arlen    (m_arlen)
   );

   assign m_arsize  = 3'(SIZE_CD);
   assign m_arburst = BURST_INCR;

   rb_return #(.DATA_W(DATA_W), .USE_DREADY(USE_DREADY)) u_ret (
      .usr_dready(usr_dready),
      .rvalid    (m_rvalid),
      .rready    (m_rready),
      .rdata     (m_rdata),
      .rresp     (m_rresp),
      .usr_data  (usr_data),
      .usr_dvalid(usr_dvalid),
      .usr_resp  (usr_resp),
      .usr_rvalid(usr_rvalid)
   );
endmodule

// File: rtl/burst_read_bridge_chk.sv
module burst_read_bridge_chk #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter int LEN_W      = 16,
   parameter bit USE_DREADY = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [LEN_W-1:0]  req_len,
   input logic              req_ready,
   input logic              usr_dready,
   input logic              usr_dvalid,
   input logic              usr_rvalid,
   input logic              m_arvalid,
   input logic              m_arready,
   input logic [ADDR_W-1:0] m_araddr,
   input logic [7:0]        m_arlen,
   input logic [2:0]        m_arsize,
   input logic [1:0]        m_arburst,
   input logic              m_rvalid,
   input logic              m_rready
);
   localparam logic [2:0] SZ = 3'($clog2(DATA_W / 8));

   // R3
   busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_arvalid |-> !req_ready);

   // R8
   ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arlen));

   // R7
   ar_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_arvalid |-> m_arburst == 2'b01 && m_arsize == SZ);

   // R9
   rready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_rready == (USE_DREADY ? usr_dready : 1'b1));

   // R10
   beat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_dvalid || usr_rvalid) |-> m_rvalid && m_rready);

   // R11
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_len == '0 |=> req_ready && !m_arvalid);
endmodule

bind burst_read_bridge burst_read_bridge_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .USE_DREADY(USE_DREADY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
   .req_ready(req_ready), .usr_dready(usr_dready), .usr_dvalid(usr_dvalid),
   .usr_rvalid(usr_rvalid), .m_arvalid(m_arvalid), .m_arready(m_arready),
   .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
   .m_arburst(m_arburst), .m_rvalid(m_rvalid), .m_rready(m_rready)
);

// File: tb/sim_burst_read_bridge.sv
module sim_burst_read_bridge;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32, DW = 64, LW = 16, MB = 256, BYTES = DW / 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_base_we = 1'b0;
   logic [AW-1:0] cfg_base = '0;
   logic req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic usr_dready = 1'b0, m_arready = 1'b0, m_rvalid = 1'b0;
   logic [DW-1:0] m_rdata = '0;
   logic [1:0] m_rresp = '0;

   logic req_ready, usr_dvalid, usr_rvalid, m_arvalid, m_rready;
   logic [DW-1:0] usr_data;
   logic [1:0] usr_resp, m_arburst;
   logic [AW-1:0] m_araddr;
   logic [7:0] m_arlen;
   logic [2:0] m_arsize;

   logic t_req_ready, t_dvalid, t_rvalid, t_arvalid, t_rready;
   logic [DW-1:0] t_data;
   logic [1:0] t_resp, t_arburst;
   logic [AW-1:0] t_araddr;
   logic [7:0] t_arlen;
   logic [2:0] t_arsize;

   int errors = 0, checks = 0;
   bit done = 1'b0;
   logic [AW-1:0] base_model = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_read_bridge #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .MAX_BEATS(MB), .USE_DREADY(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_base_we(cfg_base_we), .cfg_base(cfg_base),
      .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len), .req_ready(req_ready),
      .usr_dready(usr_dready), .usr_data(usr_data), .usr_dvalid(usr_dvalid),
      .usr_resp(usr_resp), .usr_rvalid(usr_rvalid), .m_arvalid(m_arvalid),
      .m_arready(m_arready), .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
      .m_arburst(m_arburst), .m_rvalid(m_rvalid), .m_rready(m_rready),
      .m_rdata(m_rdata), .m_rresp(m_rresp));

   burst_read_bridge #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .MAX_BEATS(MB), .USE_DREADY(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .cfg_base_we(1'b0), .cfg_base('0),
      .req_valid(1'b0), .req_addr('0), .req_len('0), .req_ready(t_req_ready),
      .usr_dready(usr_dready), .usr_data(t_data), .usr_dvalid(t_dvalid),
      .usr_resp(t_resp), .usr_rvalid(t_rvalid), .m_arvalid(t_arvalid),
      .m_arready(1'b0), .m_araddr(t_araddr), .m_arlen(t_arlen), .m_arsize(t_arsize),
      .m_arburst(t_arburst), .m_rvalid(m_rvalid), .m_rready(t_rready),
      .m_rdata(m_rdata), .m_rresp(m_rresp));

   function automatic int burst_of(input int rem);
      return (rem > MB) ? MB : rem;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_base(input logic [AW-1:0] v);
      @(negedge clk);
      cfg_base_we = 1'b1; cfg_base = v;
      @(negedge clk);
      cfg_base_we = 1'b0; cfg_base = $urandom;
      base_model = v;
   endtask

   task automatic run_req(input logic [AW-1:0] a, input int n, input bit stall);
      logic [AW-1:0] exp_a;
      int rem, b;
      bit fire;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_len = LW'(n);
      @(negedge clk);
      req_valid = 1'b0; req_addr = $urandom; req_len = LW'($urandom);   // R2 scramble
      exp_a = base_model + a;
      rem = n;
      if (n == 0) begin
         for (int k = 0; k < 3; k++) begin
            chk(!m_arvalid && req_ready, "R11 zero length ignored", {m_arvalid, req_ready}, 2'b01);
            @(negedge clk);
         end
         return;
      end
      while (rem != 0) begin
         b = burst_of(rem);
         chk(m_arvalid == 1'b1, "R3 burst pending", m_arvalid, 1);
         chk(req_ready == 1'b0, "R3 busy", req_ready, 0);
         chk(m_araddr == exp_a, "R5/R6 burst address", m_araddr, exp_a);
         chk(m_arlen == 8'(b - 1), "R4 burst length", m_arlen, b - 1);
         chk(m_arsize == 3'd3 && m_arburst == 2'b01, "R7 burst attributes",
             {m_arsize, m_arburst}, {3'd3, 2'b01});
         fire = stall ? ($urandom % 3 == 0) : 1'b1;
         m_arready = fire;
         @(negedge clk);
         m_arready = 1'b0;
         if (fire) begin
            rem -= b;
            exp_a += AW'(b * BYTES);
         end
      end
      chk(req_ready && !m_arvalid, "R3 ready after last burst", {req_ready, m_arvalid}, 2'b10);
   endtask

   initial begin
      void'($urandom(32'h5EED_0A11));
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && m_arvalid == 1'b0, "R1 reset outputs", {req_ready, m_arvalid}, 2'b10);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && m_arvalid == 1'b0, "R1 idle after reset", {req_ready, m_arvalid}, 2'b10);
      run_req(32'h0000_1000, 4, 1'b0);      // R1 base zero, R6
      run_req(32'h0000_2000, 1, 1'b0);      // R4 single beat
      run_req(32'h0001_0000, 256, 1'b1);    // R4 exact fit
      run_req(32'h0002_0000, 257, 1'b1);    // R4 one-beat remainder
      run_req(32'h0004_0000, 600, 1'b1);    // R5 three bursts
      run_req(32'h0000_0040, 0, 1'b0);      // R11
      set_base(32'h8000_0000);
      run_req(32'h0000_0100, 300, 1'b1);    // R6 with base
      for (int i = 0; i < 12; i++)
         run_req(AW'($urandom) & 32'h00FF_FFF8, int'($urandom % 700), 1'b1);
      // R9 / R10 data return on both variants
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         m_rvalid = 1'($urandom); usr_dready = 1'($urandom);
         m_rdata = {$urandom, $urandom}; m_rresp = 2'($urandom);
         #1;
         chk(m_rready == usr_dready, "R9 ready follows user", m_rready, usr_dready);
         chk(t_rready == 1'b1, "R9 tied ready", t_rready, 1);
         chk(usr_dvalid == (m_rvalid && usr_dready) && usr_rvalid == usr_dvalid,
             "R10 beat valid", {usr_dvalid, usr_rvalid}, {2{m_rvalid && usr_dready}});
         chk(t_dvalid == m_rvalid, "R10 beat valid tied", t_dvalid, m_rvalid);
         if (usr_dvalid)
            chk(usr_data == m_rdata && usr_resp == m_rresp, "R10 data and status",
                {usr_resp, usr_data[61:0]}, {m_rresp, m_rdata[61:0]});
      end
      m_rvalid = 1'b0;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule